// File: doc/BRIEF.md
# Serial Transmitter with Shared Port Pin and Break Control

This block is an asynchronous serial transmitter whose output pin is shared with a general-purpose port bit. While the transmitter is enabled it owns the pin and sends frames of one start bit, eight data bits and one stop bit. Each bit boundary falls on a one-cycle baud tick that comes from outside the block. A single-byte buffer takes bytes through a load strobe, and two flags report progress. One flag shows that the buffer is free for another byte. The other shows that the line has gone quiet after the last stop bit.

When the enable input is low, the pin is driven by a port data bit, and its output-enable follows a port direction bit. Software uses this fallback to control the line level directly. Setting direction and data both to 1 before dropping the enable holds the line in the mark (high) state. Setting direction to 1 and data to 0 before dropping the enable sends a break, and the line stays low for as long as the enable is off. Dropping the enable also resets the transmitter on the same edge. Any frame in progress is abandoned and the buffered byte is discarded.

Top module: `txpin_top`

## Requirements
- R1: While txEnable is 0, txdOe equals portDir and txdPin equals portData in the same cycle, with no clock edge in between.
- R2: With portDir=1 and portData=1 and txEnable=0, txdPin stays at 1 on every cycle, whatever baud ticks or load strobes arrive.
- R3: Clearing txEnable in the middle of a frame, with portDir=1 and portData=0, makes txdPin 0 in that same cycle, and it stays 0 while txEnable remains 0.
- R4: The first clock edge that sees txEnable=0 empties the buffer and resets the shifter. After txEnable returns to 1, txEmpty=1, txEnd=1, txdPin=1, and the aborted frame is never resumed.
- R5: While txEnable is 1, txdOe is 1. When no frame is in progress, txdPin is 1 (mark).
- R6: A frame on txdPin is a start bit of 0, then loadData bits 0 to 7 in that order (least significant first), then a stop bit of 1. Each bit changes only on the clock edge that samples baudTick=1.
- R7: A load strobe (loadValid=1) is accepted only when txEnable=1 and txEmpty=1. After the accepting edge, txEmpty is 0 and txEnd is 0.
- R8: If the transmitter is idle, the edge after a load is accepted moves the byte into the shifter. From then on txEmpty is 1 and txdPin shows the start bit.
- R9: The tick that completes the stop bit sets txEnd to 1 if the buffer is empty. If the buffer holds a byte at that tick, txEnd stays 0 and the next frame's start bit follows one cycle later.
- R10: A load strobe that arrives while txEmpty=0 is ignored. The buffered byte is the one that gets transmitted.
- R11: After reset, txEmpty=1 and txEnd=1. With txEnable=1, txdPin is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Transmitter enable; 0 hands the pin to the port bits and resets the transmitter |
| portDir | input | 1 | Port direction bit used while disabled (1 = drive) |
| portData | input | 1 | Port data bit used while disabled |
| baudTick | input | 1 | One-cycle pulse that advances one bit time |
| loadValid | input | 1 | Load strobe for loadData |
| loadData | input | 8 | Byte to transmit |
| txdPin | output | 1 | Serial line output value |
| txdOe | output | 1 | Output-enable for the serial pin |
| txEmpty | output | 1 | Buffer is free for a new byte |
| txEnd | output | 1 | Last frame finished and nothing is waiting |

## Verification
The hardest situation to reach from the ports is an abort at an arbitrary bit position while a second byte is already buffered. In that case both the shifter contents and the buffer must disappear together. The stimulus places the abort with random counts: it loads one byte, queues a second one, delivers a random number of ticks, and then drops the enable with random port bits. It then checks that the port levels appear at once, that the port levels hold while ticks and loads continue, and that the transmitter comes back idle and empty. Back-to-back frames and ignored loads into a full buffer are driven directly, and each resulting frame is compared bit by bit against the byte that should have been sent.

// File: rtl/txpin_pkg.sv
package txpin_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic loadBuf;
    logic moveShift;
    logic shiftBit;
    logic clearAll;
  } txStrobes_t;
endpackage

// File: rtl/txpin_ctrl.sv
module txpin_ctrl
  import txpin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       baudTick,
  input  logic       loadValid,
  output txStrobes_t strobes,
  output logic       txEmpty,
  output logic       txEnd,
  output logic       busy
);
  typedef enum logic {ST_IDLE, ST_SEND} txState_t;

  txState_t   state;
  logic [CNT_W-1:0] bitCnt;
  logic       bufFull;
  logic       accept;
  logic       moveNow;
  logic       lastTick;

  always_comb begin
    accept   = txEnable && loadValid && !bufFull;
    moveNow  = txEnable && bufFull && (state == ST_IDLE);
    lastTick = txEnable && (state == ST_SEND) && baudTick &&
               (bitCnt == CNT_W'(FRAME_BITS - 1));
    strobes.loadBuf   = accept;
    strobes.moveShift = moveNow;
    strobes.shiftBit  = txEnable && (state == ST_SEND) && baudTick;
    strobes.clearAll  = !txEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      bufFull <= 1'b0;
      txEnd   <= 1'b1;
    end else if (!txEnable) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      bufFull <= 1'b0;
      txEnd   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (moveNow) begin
            state  <= ST_SEND;
            bitCnt <= '0;
          end
        end
        ST_SEND: begin
          if (lastTick) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else if (baudTick) begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (accept)       bufFull <= 1'b1;
      else if (moveNow) bufFull <= 1'b0;
      if (accept)                   txEnd <= 1'b0;
      else if (lastTick && !bufFull) txEnd <= 1'b1;
    end
  end

  assign txEmpty = !bufFull;
  assign busy    = (state == ST_SEND);

  // R4
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (txEmpty && txEnd && !busy));
  // R9
  end_means_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEnd |-> (txEmpty && !busy));
  // R7
  load_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && loadValid && txEmpty) |=> (!txEmpty && !txEnd));
  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && !txEmpty && !busy) |=> busy);
endmodule

// File: rtl/txpin_dp.sv
module txpin_dp
  import txpin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           strobes,
  input  logic [DATA_BITS-1:0] loadData,
  output logic                 frameBit
);
  logic [DATA_BITS-1:0]  bufByte;
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufByte  <= '0;
      shiftReg <= '1;
    end else if (strobes.clearAll) begin
      bufByte  <= '0;
      shiftReg <= '1;
    end else begin
      if (strobes.loadBuf) bufByte <= loadData;
      if (strobes.moveShift)
        shiftReg <= {1'b1, bufByte, 1'b0};
      else if (strobes.shiftBit)
        shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end
  end

  assign frameBit = shiftReg[0];

  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.moveShift |=> !frameBit);
  // R4
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> frameBit);
endmodule

// File: rtl/txpin_top.sv
module txpin_top
  import txpin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       portDir,
  input  logic       portData,
  input  logic       baudTick,
  input  logic       loadValid,
  input  logic [7:0] loadData,
  output logic       txdPin,
  output logic       txdOe,
  output logic       txEmpty,
  output logic       txEnd
);
  txStrobes_t strobes;
  logic       frameBit;
  logic       busy;

  txpin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .baudTick(baudTick),
    .loadValid(loadValid), .strobes(strobes), .txEmpty(txEmpty),
    .txEnd(txEnd), .busy(busy)
  );

  txpin_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadData(loadData),
    .frameBit(frameBit)
  );

  assign txdPin = txEnable ? frameBit : portData;
  assign txdOe  = txEnable | portDir;

  // R1
  port_fallback_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> (txdOe == portDir && txdPin == portData));
  // R5
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && !busy) |-> (txdOe && txdPin));
  // R6
  bit_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && $past(txEnable) && !baudTick && busy && $past(busy)) |=>
      (!txEnable || $stable(txdPin) || !busy));
endmodule

// File: tb/txpin_top_bench.sv
`timescale 1ns/1ps
module txpin_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0, portDir = 1'b0, portData = 1'b0;
  logic baudTick = 1'b0, loadValid = 1'b0;
  logic [7:0] loadData = 8'h00;
  logic txdPin, txdOe, txEmpty, txEnd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  txpin_top u_txpin_top (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .portDir(portDir),
    .portData(portData), .baudTick(baudTick), .loadValid(loadValid),
    .loadData(loadData), .txdPin(txdPin), .txdOe(txdOe),
    .txEmpty(txEmpty), .txEnd(txEnd)
  );

  function automatic logic expBit(input logic [7:0] b, input int idx);
    if (idx == 0) return 1'b0;
    if (idx >= 1 && idx <= 8) return b[idx-1];
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick();
    baudTick = 1'b1;
    step();
    baudTick = 1'b0;
  endtask

  // Loads b into an idle transmitter and checks the whole frame.
  task automatic sendByte(input logic [7:0] b);
    loadValid = 1'b1; loadData = b;
    step();
    loadValid = 1'b0;
    chk("R7 empty low after load", txEmpty, 1'b0);
    chk("R7 end low after load", txEnd, 1'b0);
    step();
    chk("R8 empty after move", txEmpty, 1'b1);
    chk("R6 start bit", txdPin, expBit(b, 0));
    for (int i = 1; i < 10; i++) begin
      tick();
      chk("R6 frame bit", txdPin, expBit(b, i));
    end
    chk("R9 end before stop done", txEnd, 1'b0);
    tick();
    chk("R9 end after stop", txEnd, 1'b1);
    chk("R5 idle mark", txdPin, 1'b1);
    chk("R5 oe enabled", txdOe, 1'b1);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, bq;
    void'($urandom(32'd4711));
    step(); step();
    rstN = 1'b1;
    txEnable = 1'b1;
    step();
    // R11
    chk("R11 reset empty", txEmpty, 1'b1);
    chk("R11 reset end", txEnd, 1'b1);
    chk("R11 reset pin", txdPin, 1'b1);

    // R6 directed and random frames
    sendByte(8'h00);
    sendByte(8'hFF);
    sendByte(8'hA5);
    for (int n = 0; n < 12; n++) sendByte(8'($urandom));

    // R9 and R10: back-to-back, with an ignored load into a full buffer
    a = 8'h3C; bq = 8'hC3;
    loadValid = 1'b1; loadData = 8'h81;
    step(); step();
    loadData = a;
    step();
    chk("R10 queued not empty", txEmpty, 1'b0);
    loadData = bq;
    step();
    loadValid = 1'b0;
    for (int i = 1; i < 10; i++) tick();
    tick();
    chk("R9 end stays low with queued byte", txEnd, 1'b0);
    step();
    chk("R9 next start follows", txdPin, 1'b0);
    for (int i = 1; i < 10; i++) begin
      tick();
      chk("R10 queued byte sent", txdPin, expBit(a, i));
    end
    tick();
    chk("R10 ignored byte not sent", txEnd, 1'b1);
    step();
    chk("R10 line idle after", txdPin, 1'b1);

    // R3 break mid-frame
    portDir = 1'b1; portData = 1'b0;
    loadValid = 1'b1; loadData = 8'hFF;
    step(); step();
    loadValid = 1'b0;
    tick(); tick();
    txEnable = 1'b0;
    #0.5;
    chk("R3 break at once", txdPin, 1'b0);
    chk("R3 oe", txdOe, 1'b1);
    for (int i = 0; i < 6; i++) begin
      baudTick = i[0]; loadValid = 1'b1;
      step();
      chk("R3 break held", txdPin, 1'b0);
    end
    baudTick = 1'b0; loadValid = 1'b0;
    txEnable = 1'b1;
    #0.5;
    chk("R4 idle after abort", txdPin, 1'b1);
    chk("R4 empty after abort", txEmpty, 1'b1);
    chk("R4 end after abort", txEnd, 1'b1);
    for (int i = 0; i < 12; i++) tick();
    chk("R4 frame not resumed", txdPin, 1'b1);

    // R2 mark hold
    portDir = 1'b1; portData = 1'b1;
    txEnable = 1'b0;
    for (int i = 0; i < 6; i++) begin
      baudTick = 1'b1; loadValid = 1'b1; loadData = 8'h00;
      step();
      chk("R2 mark held", txdPin, 1'b1);
    end
    baudTick = 1'b0; loadValid = 1'b0;

    // R1 port combinations
    for (int i = 0; i < 4; i++) begin
      portDir = i[1]; portData = i[0];
      #0.5;
      chk("R1 oe follows dir", txdOe, i[1]);
      chk("R1 pin follows data", txdPin, i[0]);
      step();
    end

    // R4 random aborts with a queued byte
    for (int n = 0; n < 20; n++) begin
      int k;
      logic d, v;
      txEnable = 1'b1;
      step();
      loadValid = 1'b1; loadData = 8'($urandom);
      step(); step();
      loadData = 8'($urandom);
      step();
      loadValid = 1'b0;
      k = int'($urandom % 10);
      for (int i = 0; i < k; i++) tick();
      d = 1'($urandom); v = 1'($urandom);
      portDir = d; portData = v;
      txEnable = 1'b0;
      #0.5;
      chk("R1 abort oe", txdOe, d);
      chk("R1 abort pin", txdPin, v);
      step();
      chk("R4 empty while off", txEmpty, 1'b1);
      txEnable = 1'b1;
      for (int i = 0; i < 12; i++) begin
        tick();
        chk("R4 no resume", txdPin, 1'b1);
      end
    end
    sendByte(8'h5A);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule